// File: doc/BRIEF.md
# PCI INTx Slot-Swizzle Interrupt Router

This block gathers the four level-sensitive legacy interrupt pins (INTA..INTD, pin numbers 0..3) of three backplane slots and folds them onto four system interrupt outputs. In the normal (swizzled) mode, pin `p` of slot `s` drives output `(s + p + K) mod 4`. The slot numbers are 29, 30 and 31. Slot 29 carries the host bridge and the other two carry peripherals. The offset `K` is set by a board-variant parameter: 2 on board A and 3 on board B.

On board A the block also watches configuration-space writes. Software states which interrupt it expects a device to use by writing the interrupt-line byte. When it writes the value 27 there, it shows that it assumes the older flat routing. The block then switches to a legacy mode in which pin `p` drives output `p` whatever the slot. Any other value written to that byte returns the block to swizzled routing. Board B never snoops.

Top module: `intx_router`

## Requirements
- R1: After reset the legacy flag is clear and routing is swizzled.
- R2: On board A (outputs 0..3 = system IRQ 27..30), swizzled routing places INTA..INTD of slot 31 on IRQ 28,29,30,27, of slot 30 on 27,28,29,30, and of slot 29 on 30,27,28,29.
- R3: On board B (outputs 0..3 = system IRQ 48..51), routing places INTA..INTD of slot 31 on 50,51,48,49, of slot 30 on 49,50,51,48, and of slot 29 on 48,49,50,51.
- R4: Each output is the OR of every request currently mapped to it and follows the inputs combinationally. `dev_irq` bit `(slot-29)*4 + pin` carries one request.
- R5: On board A, a write with `cfg_wr_en` high, `cfg_addr[7:0]` in the dword holding offset 0x3C, `cfg_be[0]` set and `cfg_wdata[7:0]` = 27 sets legacy mode from the next clock edge. The slot is taken from `cfg_addr[15:11]` and must not satisfy slot mod 4 = 2.
- R6: Such a write with any other byte value clears legacy mode. The other data bytes do not matter.
- R7: A write that targets a slot with slot mod 4 = 2 (slot 30) leaves the mode unchanged.
- R8: A write with `cfg_be[0]` clear, to another offset, or with `cfg_wr_en` low leaves the mode unchanged.
- R9: In legacy mode, pin p of every slot drives output p.
- R10: On board B, configuration writes never change routing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the mode flag |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_irq | input | 12 | Level requests, bit (slot-29)*4+pin |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 16 | devfn in [15:8], register offset in [7:0] |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Byte enables, bit n covers wdata[8n+7:8n] |
| sys_irq | output | 4 | Routed system interrupt levels |

## Verification
The bench builds two copies side by side from one stimulus stream: `u_dut` with the default board A and `u_dut_b` with board B. Both see every configuration write. Board A is therefore driven through all mode transitions, including the filtered writes. Board B must hold its fixed table throughout, so R10 is checked against live snoop traffic rather than in isolation. Every single-pin and several multi-pin patterns are applied in both modes.

// File: rtl/intx_pkg.sv
package intx_pkg;
   typedef enum logic {BOARD_A = 1'b0, BOARD_B = 1'b1} board_e;

   function automatic int unsigned swz_offset(board_e b);
      return (b == BOARD_A) ? 2 : 3;
   endfunction
endpackage

// File: rtl/intx_cfg_snoop.sv
module intx_cfg_snoop #(
   parameter int          ADDR_W       = 16,
   parameter int          DATA_W       = 32,
   parameter logic [7:0]  REG_OFS      = 8'h3C,
   parameter logic [7:0]  LEGACY_CODE  = 8'd27,
   parameter int          SKIP_RESIDUE = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W/8-1:0] be,
   output logic                legacy
);
   localparam int BE_W      = DATA_W / 8;
   localparam int LANE_BITS = (BE_W > 1) ? $clog2(BE_W) : 0;
   localparam int LANE      = int'(REG_OFS) % BE_W;
   localparam int DWORD_IDX = int'(REG_OFS) >> LANE_BITS;

   initial begin
      assert (ADDR_W >= 16) else $error("address must hold devfn and offset");
      assert (DATA_W % 8 == 0) else $error("data width must be whole bytes");
   end

   logic [4:0] slot_num;
   logic [7:0] lane_byte;
   logic       ofs_ok, slot_ok, hit;

   assign slot_num  = addr[15:11];
   assign lane_byte = wdata[LANE*8 +: 8];
   assign ofs_ok    = (int'(addr[7:0]) >> LANE_BITS) == DWORD_IDX;
   assign slot_ok   = (int'(slot_num) % 4) != SKIP_RESIDUE;
   assign hit       = wr_en && ofs_ok && be[LANE] && slot_ok;

   always_ff @(posedge clk) begin
      if (!rst_n)   legacy <= 1'b0;
      else if (hit) legacy <= (lane_byte == LEGACY_CODE);
   end

   wire unused_bits = ^{1'b0, addr, wdata, be};

   assert_set_legacy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ofs_ok && be[LANE] && slot_ok && lane_byte == LEGACY_CODE) |=> legacy);
   assert_clear_legacy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ofs_ok && be[LANE] && slot_ok && lane_byte != LEGACY_CODE) |=> !legacy);
   assert_hold_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || !be[LANE] || !ofs_ok) |=> $stable(legacy));
   assert_skip_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(slot_num) % 4 == SKIP_RESIDUE) |=> $stable(legacy));
endmodule

// File: rtl/intx_swizzle_map.sv
module intx_swizzle_map #(
   parameter int NUM_SLOTS  = 3,
   parameter int NUM_OUT    = 4,
   parameter int FIRST_SLOT = 29,
   parameter int KOFS       = 2
) (
   input  logic [NUM_SLOTS*NUM_OUT-1:0] dev_irq,
   input  logic                         legacy,
   output logic [NUM_OUT-1:0]           sys_irq
);
   localparam int NREQ = NUM_SLOTS * NUM_OUT;

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      logic [NREQ-1:0] swz_hits, flat_hits;
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         for (genvar p = 0; p < NUM_OUT; p++) begin : g_pin
            localparam int RIDX = (FIRST_SLOT + s + p + KOFS) % NUM_OUT;
            localparam int BIT  = s * NUM_OUT + p;
            assign swz_hits[BIT]  = (RIDX == o) ? dev_irq[BIT] : 1'b0;
            assign flat_hits[BIT] = (p == o)    ? dev_irq[BIT] : 1'b0;
         end
      end
      assign sys_irq[o] = legacy ? |flat_hits : |swz_hits;
   end
endmodule

// File: rtl/intx_router.sv
module intx_router
   import intx_pkg::*;
#(
   parameter int          NUM_SLOTS    = 3,
   parameter int          NUM_OUT      = 4,
   parameter int          FIRST_SLOT   = 29,
   parameter board_e      BOARD        = BOARD_A,
   parameter int          ADDR_W       = 16,
   parameter int          DATA_W       = 32,
   parameter logic [7:0]  IRQ_LINE_OFS = 8'h3C,
   parameter logic [7:0]  LEGACY_CODE  = 8'd27,
   parameter int          SKIP_RESIDUE = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_SLOTS*NUM_OUT-1:0] dev_irq,
   input  logic                         cfg_wr_en,
   input  logic [ADDR_W-1:0]            cfg_addr,
   input  logic [DATA_W-1:0]            cfg_wdata,
   input  logic [DATA_W/8-1:0]          cfg_be,
   output logic [NUM_OUT-1:0]           sys_irq
);
   localparam int  KOFS     = int'(swz_offset(BOARD));
   localparam bit  SNOOP_EN = (BOARD == BOARD_A);

   initial begin
      assert (NUM_OUT == 4) else $error("legacy INTx has four pins");
      assert (FIRST_SLOT + NUM_SLOTS <= 32) else $error("slot number exceeds 5 bits");
   end

   logic legacy_mode;

   if (SNOOP_EN) begin : g_snoop
      intx_cfg_snoop #(
         .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFS(IRQ_LINE_OFS),
         .LEGACY_CODE(LEGACY_CODE), .SKIP_RESIDUE(SKIP_RESIDUE)
      ) u_snoop (
         .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
         .wdata(cfg_wdata), .be(cfg_be), .legacy(legacy_mode)
      );
   end else begin : g_fixed
      assign legacy_mode = 1'b0;
      wire unused_cfg = ^{1'b0, cfg_wr_en, cfg_addr, cfg_wdata, cfg_be};

      assert_fixed_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
         $stable(dev_irq) |-> $stable(sys_irq));
   end

   intx_swizzle_map #(
      .NUM_SLOTS(NUM_SLOTS), .NUM_OUT(NUM_OUT),
      .FIRST_SLOT(FIRST_SLOT), .KOFS(KOFS)
   ) u_map (
      .dev_irq(dev_irq), .legacy(legacy_mode), .sys_irq(sys_irq)
   );

   assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_irq == '0) |-> (sys_irq == '0));
   assert_no_amplify_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sys_irq) <= $countones(dev_irq));
   assert_reset_mode_R1: assert property (@(posedge clk)
      !rst_n |=> !legacy_mode);

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk_slot
      for (genvar p = 0; p < NUM_OUT; p++) begin : g_chk_pin
         assert_legacy_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (legacy_mode && dev_irq[s*NUM_OUT+p]) |-> sys_irq[p]);
      end
   end
endmodule

// File: tb/intx_router_tb.sv
module intx_router_tb;
   import intx_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] dev_irq = '0;
   logic        cfg_wr_en = 1'b0;
   logic [15:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [3:0]  cfg_be = '0;
   logic [3:0]  sys_a, sys_b;

   int n_chk = 0;
   int n_fail = 0;
   bit exp_leg = 1'b0;
   bit done = 1'b0;

   // system IRQ numbers per [slot-29][pin], from R2 / R3
   localparam int TAB_A [3][4] = '{'{30,27,28,29}, '{27,28,29,30}, '{28,29,30,27}};
   localparam int TAB_B [3][4] = '{'{48,49,50,51}, '{49,50,51,48}, '{50,51,48,49}};

   always #(CLK_PERIOD/2) clk = ~clk;

   intx_router #(.BOARD(BOARD_A)) u_dut (
      .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .cfg_wr_en(cfg_wr_en),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .sys_irq(sys_a));
   intx_router #(.BOARD(BOARD_B)) u_dut_b (
      .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .cfg_wr_en(cfg_wr_en),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .sys_irq(sys_b));

   function automatic logic [3:0] model(input bit brd_b, input bit leg, input logic [11:0] v);
      logic [3:0] r = '0;
      for (int s = 0; s < 3; s++)
         for (int p = 0; p < 4; p++)
            if (v[s*4+p]) begin
               if (leg) r[p] = 1'b1;
               else if (brd_b) r[TAB_B[s][p] - 48] = 1'b1;
               else r[TAB_A[s][p] - 27] = 1'b1;
            end
      return r;
   endfunction

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic apply(input logic [11:0] v, input string ra, input string rb);
      @(negedge clk);
      dev_irq = v;
      #1;
      check(ra, sys_a, model(1'b0, exp_leg, v));
      check(rb, sys_b, model(1'b1, 1'b0, v));
   endtask

   task automatic cfg_write(input int slot, input logic [7:0] ofs,
                            input logic [31:0] d, input logic [3:0] be, input bit strobe);
      @(negedge clk);
      cfg_wr_en = strobe;
      cfg_addr  = {slot[4:0], 3'd0, ofs};
      cfg_wdata = d;
      cfg_be    = be;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      cfg_addr  = '0;
      cfg_be    = '0;
   endtask

   // slot 31 INTA probe: swizzled A -> out1, legacy -> out0, B -> out2
   task automatic probe(input string req);
      apply(12'h100, req, "R10 board B unchanged");
   endtask

   task automatic t_reset;
      #1;
      check("R1 outputs idle in reset", sys_a, 4'b0000);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      probe("R1 swizzled after reset");
   endtask

   task automatic t_single_pins;
      for (int i = 0; i < 12; i++)
         apply(12'(1) << i, "R2 board A single pin", "R3 board B single pin");
   endtask

   task automatic t_multi;
      apply(12'hFFF, "R4 all requests", "R4 all requests B");
      apply(12'h012, "R4 shared output OR", "R4 shared output OR B");
      apply(12'hA50, "R4 mixed pattern", "R4 mixed pattern B");
      apply(12'h000, "R4 idle", "R4 idle B");
   endtask

   task automatic t_snoop_set;
      cfg_write(31, 8'h3C, 32'h0000_001B, 4'b0001, 1'b1);
      exp_leg = 1'b1;
      probe("R5 legacy set by slot 31 write");
   endtask

   task automatic t_legacy_route;
      for (int i = 0; i < 12; i++)
         apply(12'(1) << i, "R9 legacy single pin", "R10 board B single pin");
      apply(12'h3C6, "R9 legacy multi", "R10 board B multi");
   endtask

   task automatic t_ignored;
      cfg_write(30, 8'h3C, 32'h0000_0005, 4'b0001, 1'b1);
      probe("R7 slot 30 write ignored");
      cfg_write(31, 8'h3C, 32'h0000_0005, 4'b1110, 1'b1);
      probe("R8 byte lane 0 disabled");
      cfg_write(31, 8'h40, 32'h0000_0005, 4'b1111, 1'b1);
      probe("R8 other offset");
      cfg_write(31, 8'h3C, 32'h0000_0005, 4'b0001, 1'b0);
      probe("R8 strobe low");
   endtask

   task automatic t_clear;
      cfg_write(29, 8'h3C, 32'h0000_002A, 4'b0001, 1'b1);
      exp_leg = 1'b0;
      probe("R6 cleared by other value");
      cfg_write(31, 8'h3C, 32'h1234_561B, 4'b0001, 1'b1);
      exp_leg = 1'b1;
      probe("R5 only lane byte compared");
      cfg_write(31, 8'h3C, 32'h0000_1B00, 4'b0011, 1'b1);
      exp_leg = 1'b0;
      probe("R6 value 27 in wrong byte clears");
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_single_pins();
      t_multi();
      t_snoop_set();
      t_legacy_route();
      t_ignored();
      t_clear();
      t_single_pins();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule